// File: doc/BRIEF.md
# Bit-Serial Adder/Subtractor

This unit adds or subtracts two unsigned WIDTH-bit words using a single one-bit full adder. Both words are captured in parallel into shift registers when a start request is accepted. They are then fed to the adder one bit per enabled clock, lowest bit first. The adder's carry is held in a flip-flop between steps. Each sum bit enters a result shift register from the top, so after WIDTH steps the parallel result is aligned. For subtraction, the second word is inverted as it is captured and the carry flip-flop is preset to one. This forms the two's complement difference.

A small down-counter sequences the steps. A one-cycle done strobe marks the capture of the last sum bit. A clock-enable input gates every state change, so the unit can be paced slower than its clock. An asynchronous active-high reset clears the carry, the result and the sequencer. The unit trades WIDTH cycles of latency for a datapath of one full adder and three shift registers.

Top module: `bitser_addsub`

## Requirements
- R1: While or just after `rst` is high, `result` is 0, `carry_out` is 0 and `done` is 0; reset acts without waiting for a clock edge.
- R2: With `sub_sel`=0 at start, when `done` is high `result` equals (op_a + op_b) mod 2^WIDTH and `carry_out` equals bit WIDTH of the unsigned sum.
- R3: With `sub_sel`=1 at start, the second operand is inverted and the carry is preset to 1. When `done` is high, `result` equals (op_a - op_b) mod 2^WIDTH and `carry_out` is 1 exactly when op_a >= op_b (unsigned).
- R4: A start is accepted on a rising edge where `start`=1 and `ce`=1. `done` goes high right after the WIDTH-th later rising edge with `ce`=1, and not earlier.
- R5: `done` is high for exactly one clock cycle per completed operation. It falls on the next rising edge whether or not `ce` is high.
- R6: On edges with `ce`=0 nothing advances: `result`, `carry_out` and the step count hold, and a `start` on such an edge is ignored.
- R7: After `done`, `result` and `carry_out` stay unchanged until the next accepted start.
- R8: A start accepted while an operation is running abandons it. The new operands are then processed from the beginning, with the timing of R4.
- R9: Operands and `sub_sel` are sampled only when a start is accepted. Changing them while an operation runs does not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high clear |
| ce | input | 1 | Clock enable; all state advances only when high |
| start | input | 1 | Load operands and begin an operation |
| sub_sel | input | 1 | 0 = add, 1 = subtract (op_a - op_b) |
| op_a | input | WIDTH | First operand, parallel |
| op_b | input | WIDTH | Second operand, parallel |
| result | output | WIDTH | Parallel result, valid from done until next start |
| carry_out | output | 1 | Final carry; for subtraction 1 means no borrow |
| done | output | 1 | One-cycle strobe after the last sum bit is captured |

## Verification
The assertions check five things on every cycle:
- the carry preset that follows each accepted start;
- that done lasts a single cycle;
- that done coincides with an empty step count;
- that the outputs freeze on disabled clocks;
- that the outputs stay unchanged while the sequencer is idle.

The arithmetic itself can only be shown by the bench's scenarios, because it is visible only after a whole serial pass. These scenarios cover sums and differences at the carry and borrow boundaries, the exact done cycle, and operand changes during a run. They also cover a run stretched by disabled clocks, a restart in mid-run, and a reset that arrives between edges.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    // Output of one full-adder step.
    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    // Sequencer phase.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_phase_t;

    // One-bit full adder: parity of the inputs, and their majority.
    function automatic fa_out_t full_add(input logic x, input logic y, input logic cin);
        fa_out_t r;
        r.sum   = x ^ y ^ cin;
        r.carry = (x & y) | (x & cin) | (y & cin);
        return r;
    endfunction

    // Bits needed to count from 0 to n inclusive.
    function automatic int count_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bsa_operand_sr.sv
module bsa_operand_sr #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             invert,
    input  logic [WIDTH-1:0] par_in,
    output logic             lsb
);
    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= invert ? ~par_in : par_in;
        end else if (step) begin
            sr_q <= {1'b0, sr_q[WIDTH-1:1]};
        end
    end

    assign lsb = sr_q[0];

endmodule

// File: rtl/bsa_adder_cell.sv
module bsa_adder_cell
    import bsa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    input  logic preset,
    input  logic bit_a,
    input  logic bit_b,
    output logic sum_bit,
    output logic carry_q
);
    fa_out_t fa;

    always_comb begin
        fa = full_add(bit_a, bit_b, carry_q);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            carry_q <= 1'b0;
        end else if (load) begin
            carry_q <= preset;
        end else if (step) begin
            carry_q <= fa.carry;
        end
    end

    assign sum_bit = fa.sum;

    AST_CARRY_PRESET: assert property (@(posedge clk) disable iff (rst)
        load |=> (carry_q == $past(preset))) else $error("carry preset wrong"); // R3

endmodule

// File: rtl/bsa_sequencer.sv
module bsa_sequencer
    import bsa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic start,
    output logic load,
    output logic step,
    output logic idle,
    output logic done
);
    localparam int CW = count_bits(WIDTH);

    seq_phase_t       phase_q;
    logic [CW-1:0]    left_q;

    assign load = ce & start;
    assign step = ce & ~start & (phase_q == SEQ_RUN);
    assign idle = (phase_q == SEQ_IDLE);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            phase_q <= SEQ_IDLE;
            left_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                phase_q <= SEQ_RUN;
                left_q  <= CW'(WIDTH);
            end else if (step) begin
                left_q <= left_q - CW'(1);
                if (left_q == CW'(1)) begin
                    phase_q <= SEQ_IDLE;
                    done    <= 1'b1;
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done wider than one cycle"); // R5

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        done |-> (left_q == '0)) else $error("done before last step"); // R4

endmodule

// File: rtl/bsa_result_sr.sv
module bsa_result_sr #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             sum_bit,
    output logic [WIDTH-1:0] par_out
);
    generate
        if (WIDTH == 1) begin : g_one
            always_ff @(posedge clk or posedge rst) begin
                if (rst) par_out <= '0;
                else if (step) par_out <= sum_bit;
            end
        end else begin : g_many
            always_ff @(posedge clk or posedge rst) begin
                if (rst) par_out <= '0;
                else if (step) par_out <= {sum_bit, par_out[WIDTH-1:1]};
            end
        end
    endgenerate

endmodule

// File: rtl/bitser_addsub.sv
module bitser_addsub
    import bsa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             start,
    input  logic             sub_sel,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             done
);
    logic load, step, idle;
    logic bit_a, bit_b, sum_bit;

    bsa_sequencer #(.WIDTH(WIDTH)) u_seq (
        .clk(clk), .rst(rst), .ce(ce), .start(start),
        .load(load), .step(step), .idle(idle), .done(done)
    );

    bsa_operand_sr #(.WIDTH(WIDTH)) u_opa (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .invert(1'b0), .par_in(op_a), .lsb(bit_a)
    );

    bsa_operand_sr #(.WIDTH(WIDTH)) u_opb (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .invert(sub_sel), .par_in(op_b), .lsb(bit_b)
    );

    bsa_adder_cell u_cell (
        .clk(clk), .rst(rst), .load(load), .step(step), .preset(sub_sel),
        .bit_a(bit_a), .bit_b(bit_b), .sum_bit(sum_bit), .carry_q(carry_out)
    );

    bsa_result_sr #(.WIDTH(WIDTH)) u_res (
        .clk(clk), .rst(rst), .step(step), .sum_bit(sum_bit), .par_out(result)
    );

    AST_CE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(result) && $stable(carry_out))) else $error("state moved with ce low"); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (idle && !(ce && start)) |=> ($stable(result) && $stable(carry_out))) else $error("idle output moved"); // R7

endmodule

// File: tb/tb_bitser_addsub.sv
`timescale 1ns/1ps
module tb_bitser_addsub;
    localparam int W = 8;
    localparam int NV = 12;
    // {sub_sel, op_a, op_b}
    localparam logic [2*W:0] VEC [NV] = '{
        {1'b0, 8'd3,   8'd5},
        {1'b0, 8'd255, 8'd1},
        {1'b0, 8'd200, 8'd100},
        {1'b0, 8'd0,   8'd0},
        {1'b0, 8'd255, 8'd255},
        {1'b0, 8'hAA,  8'h55},
        {1'b1, 8'd10,  8'd3},
        {1'b1, 8'd0,   8'd1},
        {1'b1, 8'd77,  8'd77},
        {1'b1, 8'd3,   8'd200},
        {1'b1, 8'd255, 8'd0},
        {1'b1, 8'h80,  8'h7F}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b1;
    logic start = 1'b0;
    logic sub_sel = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [W-1:0] result;
    logic carry_out, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bitser_addsub #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .ce(ce), .start(start), .sub_sel(sub_sel),
        .op_a(op_a), .op_b(op_b), .result(result), .carry_out(carry_out), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W:0] model(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        logic c;
        if (s) begin
            r = a - b;
            c = (a >= b);
        end else begin
            {c, r} = {1'b0, a} + {1'b0, b};
        end
        return {c, r};
    endfunction

    // Launch at a negedge; leave at the negedge after the load edge with start low
    task automatic launch(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        sub_sel = s; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sub_sel = ~s; op_a = ~a; op_b = a ^ b; // R9: changes mid-run must not matter
    endtask

    task automatic finish_and_check(input string tag, input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] e;
        e = model(s, a, b);
        repeat (W-1) @(negedge clk);
        check({tag, " R4 done not early"}, done, 1'b0);
        @(negedge clk);
        check({tag, " R4 done on time"}, done, 1'b1);
        check({tag, s ? " R3 diff" : " R2 sum"}, result, e[W-1:0]);
        check({tag, s ? " R3 borrow" : " R2 carry"}, carry_out, e[W]);
        @(negedge clk);
        check({tag, " R5 done one cycle"}, done, 1'b0);
        check({tag, " R7 result held"}, result, e[W-1:0]);
    endtask

    initial begin
        logic [W-1:0] snap;
        logic snap_c;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 result reset", result, '0);
        check("R1 carry reset", carry_out, 1'b0);
        check("R1 done reset", done, 1'b0);
        rst = 1'b0;

        // R2 / R3 / R9 vector table
        for (int i = 0; i < NV; i++) begin
            launch(VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0]);
            finish_and_check("vec", VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0]);
        end

        // R7: long hold after done
        repeat (10) @(negedge clk);
        check("R7 hold result", result, 8'h01);
        check("R7 hold carry", carry_out, 1'b1);

        // R6: ce low mid-run freezes state, start ignored
        launch(1'b0, 8'd100, 8'd27);
        repeat (3) @(negedge clk);
        ce = 1'b0;
        snap = result; snap_c = carry_out;
        @(negedge clk);
        start = 1'b1; op_a = 8'd1; op_b = 8'd1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 result frozen", result, snap);
        check("R6 carry frozen", carry_out, snap_c);
        check("R6 no done", done, 1'b0);
        ce = 1'b1;
        // 3 steps done before freeze; W-3 remain
        repeat (W-4) @(negedge clk);
        check("R6 done not early", done, 1'b0);
        @(negedge clk);
        check("R6 done after enabled steps", done, 1'b1);
        check("R6 stretched sum", result, 8'd127);

        // R8: restart in mid-run
        launch(1'b0, 8'd9, 8'd9);
        repeat (3) @(negedge clk);
        launch(1'b1, 8'd50, 8'd60);
        finish_and_check("R8 restart", 1'b1, 8'd50, 8'd60);

        // R1: asynchronous reset between edges
        launch(1'b0, 8'd1, 8'd2);
        repeat (W + 1) @(negedge clk);
        #1 rst = 1'b1;
        #0.5;
        check("R1 async result", result, '0);
        check("R1 async carry", carry_out, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        check("R1 done after reset", done, 1'b0);

        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule